// File: doc/BRIEF.md
# Time-Base Counter with Sticky Overflow Flag and Idle Halt

This block is the time base of a small controller core. An up-counter advances either once per instruction cycle or once per rising edge of an external event input, and its wrap from all ones to zero sets a sticky overflow flag. The core polls that flag with a test operation. If the flag is set, the test raises a skip request for the next instruction and clears the flag. If it is clear, execution simply continues.

Writing the counter with a value whose top bit is one also sets the flag. Software can therefore pre-arm the flag or choose the period of the next overflow. An idle operation halts the core: the block raises a halt output that gates the rest of the core, while the counter keeps running. The first wrap releases the halt. In event-counting builds the idle operation is not allowed, and the block ignores it.

All core operations are single-cycle strobes that the block takes only on a cycle-enable clock, and only while it is not halted.

Top module: `tmr_ovf_idle`

## Requirements
- R1: After a synchronous active-low reset the count is 0, the halt output is low and the overflow flag is clear, so a test after reset gives no skip.
- R2: In cycle mode (SRC = SRC_CYCLE), the count rises by one on every clock with cyc_en high. It holds when cyc_en is low.
- R3: A wrap of the count from all ones to zero sets the overflow flag.
- R4: skip_req is high while test_stb and cyc_en are high, the block is not halted and the flag is set. The flag then clears on that clock. A test while the flag is clear gives no skip.
- R5: ld_stb with cyc_en (not halted) loads ld_val into the count on that clock instead of incrementing. If ld_val bit 7 (the top bit) is 1, the flag is set. Strobes with cyc_en low are ignored.
- R6: A flag set (wrap or load) on the same clock as a clearing test wins, so the flag stays set.
- R7: In cycle mode, idle_stb with cyc_en raises halt on that clock. The count keeps advancing while halted. Halt falls on the clock where the count wraps to zero, and that wrap leaves the flag set.
- R8: While halt is high, ld_stb, test_stb and idle_stb have no effect, and skip_req stays low.
- R9: In event mode (SRC = SRC_EVENT), the count rises once per rising edge of evt_in after a synchroniser of SYNC_STAGES flops. cyc_en does not advance it.
- R10: In event mode, idle_stb is ignored and halt stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable; qualifies all strobes and the cycle-mode tick |
| ld_stb | input | 1 | Load the counter from ld_val |
| ld_val | input | W | Load value |
| test_stb | input | 1 | Test-and-clear the overflow flag |
| idle_stb | input | 1 | Enter idle until the next overflow |
| evt_in | input | 1 | Asynchronous external event input (event mode only) |
| skip_req | output | 1 | Skip the next instruction (combinational during a test) |
| halt | output | 1 | Core halted, waiting for overflow |
| count | output | W | Current counter value |

## Verification
The bench goes after the collisions in this block. It runs a test on the very clock of a wrap. A design that lets the clear win here would lose an overflow and skip only once. It also loads with the top bit set and then tests. A design that sets the flag only from wraps would miss the skip.

Further tests strobe load and test while the core is halted. A design that does not block them would jump the count or raise skip_req while the core is stopped. The bench also checks that halt falls exactly at the wrap to zero, which catches an off-by-one wake. In event mode it confirms that cycle enables do not count and that an idle request never halts.

// File: rtl/tmr_pkg.sv
// Package: shared types for the time-base counter block.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tmr_pkg;

    // Source that advances the counter.
    typedef enum logic {
        SRC_CYCLE = 1'b0,   // one tick per instruction cycle
        SRC_EVENT = 1'b1    // one tick per external rising edge
    } tick_src_e;

    // Default counter width.
    localparam int unsigned TMR_W_DEF = 8;

    // Default synchroniser depth for the event input.
    localparam int unsigned SYNC_DEF = 2;

endpackage

// File: rtl/tmr_tick_gen.sv
// Module: tmr_tick_gen
// Produces the one-clock tick that advances the counter.
// In cycle mode the tick is cyc_en itself. In event mode evt_in is
// synchronised through SYNC_STAGES flops and a rising edge yields one tick.
// Assumes evt_in pulses stay high and low for at least one clock after sync.
module tmr_tick_gen
    import tmr_pkg::*;
#(
    parameter tick_src_e   SRC         = SRC_CYCLE,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic evt_in,
    output logic tick
);

    generate
        if (SRC == SRC_EVENT) begin : g_event
            logic [SYNC_STAGES-1:0] sync_q;
            logic                   last_q;
            logic                   unused_cyc;

            assign unused_cyc = cyc_en;

            // Shift the asynchronous event input through the synchroniser.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q <= {sync_q[SYNC_STAGES-2:0], evt_in};
                end
            end

            // Remember the previous synchronised level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    last_q <= 1'b0;
                end else begin
                    last_q <= sync_q[SYNC_STAGES-1];
                end
            end

            // One tick per rising edge of the synchronised event.
            always_comb begin
                tick = sync_q[SYNC_STAGES-1] & ~last_q;
            end
        end else begin : g_cycle
            logic unused_evt;

            assign unused_evt = evt_in;

            // Every enabled instruction cycle is a tick.
            always_comb begin
                tick = cyc_en;
            end
        end
    endgenerate

endmodule

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// The W-bit up-counter. A load has priority over a tick on the same clock.
// Flags a wrap when a tick takes the count from all ones to zero.
// Assumes ld_fire is already qualified by cycle enable and halt.
module tmr_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld_fire,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] count,
    output logic         wrap
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] count_q;
    logic [W-1:0] count_d;

    // A wrap happens only on a tick that is not displaced by a load.
    always_comb begin
        wrap = tick & ~ld_fire & (count_q == ALL_ONES);
    end

    // Choose between load, increment and hold.
    always_comb begin
        if (ld_fire) begin
            count_d = ld_val;
        end else if (tick) begin
            count_d = count_q + 1'b1;
        end else begin
            count_d = count_q;
        end
    end

    // Counter state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/tmr_ctrl.sv
// Module: tmr_ctrl
// Holds the sticky overflow flag and the idle halt.
// The flag is set by a wrap or by a load whose top bit is one. A test clears
// it, but a set on the same clock wins. Halt is entered by an idle request
// and left on a wrap.
// Assumes test_fire, idle_fire and ld_fire are already qualified.
module tmr_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic ld_msb_set,
    input  logic test_fire,
    input  logic idle_fire,
    output logic skip_req,
    output logic halt
);

    logic flag_q;
    logic halt_q;
    logic flag_set;
    logic flag_clr;

    // Sources that set and clear the sticky flag.
    always_comb begin
        flag_set = wrap | ld_msb_set;
        flag_clr = test_fire & flag_q;
    end

    // The skip request reflects the flag as seen by the test.
    always_comb begin
        skip_req = test_fire & flag_q;
    end

    // Sticky overflow flag; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_set | (flag_q & ~flag_clr);
        end
    end

    // Idle halt: entered on request, left on the next wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else begin
            halt_q <= idle_fire | (halt_q & ~wrap);
        end
    end

    assign halt = halt_q;

endmodule

// File: rtl/tmr_ovf_idle.sv
// Module: tmr_ovf_idle (top)
// Time-base counter with a sticky overflow flag, a skip-on-flag test and an
// idle halt. Strobes act only on cyc_en clocks while not halted. Idle is
// refused in event mode.
// Assumes strobes are mutually compatible single-cycle pulses from the core.
module tmr_ovf_idle
    import tmr_pkg::*;
#(
    parameter int unsigned W           = TMR_W_DEF,
    parameter tick_src_e   SRC         = SRC_CYCLE,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_en,
    input  logic         ld_stb,
    input  logic [W-1:0] ld_val,
    input  logic         test_stb,
    input  logic         idle_stb,
    input  logic         evt_in,
    output logic         skip_req,
    output logic         halt,
    output logic [W-1:0] count
);

    localparam logic IDLE_ALLOWED = (SRC == SRC_CYCLE);

    logic op_ok;
    logic ld_fire;
    logic test_fire;
    logic idle_fire;
    logic tick;
    logic wrap;

    // Qualify core strobes by cycle enable and the halt state.
    always_comb begin
        op_ok     = cyc_en & ~halt;
        ld_fire   = ld_stb & op_ok;
        test_fire = test_stb & op_ok;
        idle_fire = idle_stb & op_ok & IDLE_ALLOWED;
    end

    tmr_tick_gen #(
        .SRC         (SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc_en (cyc_en),
        .evt_in (evt_in),
        .tick   (tick)
    );

    tmr_counter #(
        .W (W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ld_fire (ld_fire),
        .ld_val  (ld_val),
        .count   (count),
        .wrap    (wrap)
    );

    tmr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (wrap),
        .ld_msb_set (ld_fire & ld_val[W-1]),
        .test_fire  (test_fire),
        .idle_fire  (idle_fire),
        .skip_req   (skip_req),
        .halt       (halt)
    );

endmodule

// File: rtl/tmr_ovf_idle_chk.sv
// Module: tmr_ovf_idle_chk
// Assertion checker bound to tmr_ovf_idle; observes ports only.
module tmr_ovf_idle_chk
    import tmr_pkg::*;
#(
    parameter int unsigned W   = TMR_W_DEF,
    parameter tick_src_e   SRC = SRC_CYCLE
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cyc_en,
    input logic         ld_stb,
    input logic [W-1:0] ld_val,
    input logic         test_stb,
    input logic         idle_stb,
    input logic         skip_req,
    input logic         halt,
    input logic [W-1:0] count
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic         CYC_MODE = (SRC == SRC_CYCLE);

    // R1: reset forces count to zero and halt low.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (count == '0) && !halt);

    // R2: enabled cycles without a load advance the count.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        CYC_MODE && cyc_en && !(ld_stb && !halt)
        |=> count == W'($past(count) + 1'b1));

    // R2: count holds without cycle enable.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        CYC_MODE && !cyc_en |=> $stable(count));

    // R5: a qualified load writes the load value.
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb && cyc_en && !halt |=> count == $past(ld_val));

    // R4: a skip clears the flag unless a set coincides.
    p_skip_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        CYC_MODE && skip_req && !(count == ALL_ONES && cyc_en)
        && !(ld_stb && ld_val[W-1]) |=> !skip_req);

    // R7: halt ends on the wrap clock.
    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt && cyc_en && count == ALL_ONES |=> !halt);

    // R8: halt persists until a wrap.
    p_halt_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt && count != ALL_ONES |=> halt);

    // R8: no skip while halted.
    p_no_skip_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !skip_req);

    // R10: event mode never halts.
    p_no_idle_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !CYC_MODE |-> !halt);

    // R7: a qualified idle request halts on the next clock.
    p_idle_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        CYC_MODE && idle_stb && cyc_en && !halt && count != ALL_ONES |=> halt);

endmodule

bind tmr_ovf_idle tmr_ovf_idle_chk #(
    .W   (W),
    .SRC (SRC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .ld_stb   (ld_stb),
    .ld_val   (ld_val),
    .test_stb (test_stb),
    .idle_stb (idle_stb),
    .skip_req (skip_req),
    .halt     (halt),
    .count    (count)
);

// File: tb/tb_tmr_ovf_idle.sv
// Bench for tmr_ovf_idle: vector table, then directed corner cases.
module tb_tmr_ovf_idle;
    import tmr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int NVEC       = 18;

    // Vector: {ld, ld_val[7:0], test, cyc, exp_skip, exp_count[7:0]}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h01},  // R2 step
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01},  // R2 hold
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h02},  // R1 flag clear after reset
        {1'b1, 8'h10, 1'b0, 1'b1, 1'b0, 8'h10},  // R5 load
        {1'b1, 8'h85, 1'b0, 1'b1, 1'b0, 8'h85},  // R5 load msb set
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h86},  // R4 skip
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h87},  // R4 cleared
        {1'b1, 8'hFE, 1'b0, 1'b1, 1'b0, 8'hFE},  // R5
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'hFF},  // R4
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00},  // R3 wrap
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h01},  // R3 flag from wrap
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h02},  // R4
        {1'b1, 8'h7F, 1'b0, 1'b1, 1'b0, 8'h7F},  // R5 msb clear
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h80},  // R5 no flag
        {1'b1, 8'hC0, 1'b0, 1'b1, 1'b0, 8'hC0},  // R5
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hC0},  // R4 test needs cyc_en
        {1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 8'hC0},  // R5 load needs cyc_en
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'hC1}   // R4 flag kept
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cyc_en = 1'b0;
    logic         ld_stb = 1'b0;
    logic [W-1:0] ld_val = '0;
    logic         test_stb = 1'b0;
    logic         idle_stb = 1'b0;
    logic         idle_e = 1'b0;
    logic         evt_in = 1'b0;
    logic         skip_req, halt;
    logic [W-1:0] count;
    logic         skip_e, halt_e;
    logic [W-1:0] count_e;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_ovf_idle #(.W(W), .SRC(SRC_CYCLE)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ld_stb(ld_stb),
        .ld_val(ld_val), .test_stb(test_stb), .idle_stb(idle_stb),
        .evt_in(evt_in), .skip_req(skip_req), .halt(halt), .count(count));

    tmr_ovf_idle #(.W(W), .SRC(SRC_EVENT)) dut_evt (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ld_stb(1'b0),
        .ld_val('0), .test_stb(1'b0), .idle_stb(idle_e),
        .evt_in(evt_in), .skip_req(skip_e), .halt(halt_e), .count(count_e));

    task automatic check(input logic ok, input string req,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive strobes just after a falling edge, settle.
    task automatic drive(input logic ld, input logic [W-1:0] v,
                         input logic tst, input logic idl, input logic cy);
        ld_stb = ld; ld_val = v; test_stb = tst; idle_stb = idl; cyc_en = cy;
        #1;
    endtask

    // Clock through one edge and return to the middle of the low phase.
    task automatic tick_once();
        @(posedge clk);
        @(negedge clk);
        ld_stb = 1'b0; test_stb = 1'b0; idle_stb = 1'b0; idle_e = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(count == 8'h00, "R1 count", count, 0);
        check(!halt, "R1 halt", halt, 0);
        check(count_e == 8'h00 && !halt_e, "R1 event dut", count_e, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][19], VEC[i][18:11], VEC[i][10], 1'b0, VEC[i][9]);
            check(skip_req == VEC[i][8], $sformatf("vec%0d skip R4", i),
                  skip_req, VEC[i][8]);
            tick_once();
            check(count == VEC[i][7:0], $sformatf("vec%0d count R2/R5", i),
                  count, VEC[i][7:0]);
        end

        // R6: load FF (flag set), test on the wrap clock keeps flag
        drive(1'b1, 8'hFF, 1'b0, 1'b0, 1'b1); tick_once();
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
        check(skip_req, "R6 first skip", skip_req, 1);
        tick_once();
        check(count == 8'h00, "R3 wrap", count, 0);
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
        check(skip_req, "R6 flag survives clear", skip_req, 1);
        tick_once();
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
        check(!skip_req, "R6 then cleared", skip_req, 0);
        tick_once();

        // R7: idle ignored without cyc_en
        drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0); tick_once();
        check(!halt, "R7 idle needs cyc_en", halt, 0);

        // R7: enter idle at F1
        drive(1'b1, 8'hF0, 1'b0, 1'b0, 1'b1); tick_once();
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b1); tick_once();   // clear flag
        drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b1); tick_once();
        check(halt, "R7 halt entered", halt, 1);
        check(count == 8'hF2, "R7 counting", count, 8'hF2);

        // R8: strobes ignored while halted
        drive(1'b1, 8'h22, 1'b1, 1'b1, 1'b1);
        check(!skip_req, "R8 no skip halted", skip_req, 0);
        tick_once();
        check(count == 8'hF3, "R8 load ignored", count, 8'hF3);
        check(halt, "R8 still halted", halt, 1);

        for (int k = 0; k < 12; k++) begin
            drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1); tick_once();
        end
        check(count == 8'hFF && halt, "R7 halt until wrap", count, 8'hFF);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1); tick_once();
        check(count == 8'h00, "R7 wrap count", count, 0);
        check(!halt, "R7 wake on wrap", halt, 0);
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
        check(skip_req, "R7 flag after wake", skip_req, 1);
        tick_once();

        // R9 / R10 event mode
        cyc_en = 1'b1;
        repeat (5) tick_once();
        check(count_e == 8'h00, "R9 cyc_en no count", count_e, 0);
        idle_e = 1'b1; #1; tick_once();
        check(!halt_e, "R10 idle ignored", halt_e, 0);
        for (int p = 0; p < 3; p++) begin
            evt_in = 1'b1; repeat (3) tick_once();
            evt_in = 1'b0; repeat (3) tick_once();
        end
        repeat (3) tick_once();
        check(count_e == 8'h03, "R9 edge count", count_e, 3);
        check(!halt_e, "R10 never halted", halt_e, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule